// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Identification

This block is the serial test port of a memory device. Four test signals (clock, mode select, serial data in and serial data out) steer a sixteen-state controller. The controller routes either a three-bit instruction register or one of three data registers between the serial input and output: a 32-bit identification word, a one-bit bypass stage, or a boundary-scan chain. The boundary chain samples the device's pins. It can also preload values that are later driven onto them.

The chain ends in one extra cell that no pin owns. While the external-test instruction is current, the value latched into that cell decides whether the device's data output drivers are enabled. A separate sample instruction that floats the outputs forces those drivers off. Every other instruction leaves the output enable of the functional core untouched. An active-low reset input plays the part of power-on. Five test clocks with mode select high reach the same controller state.

Top module: `scan_port`

## Requirements
- R1: From any controller state, five rising test clocks with `tms` high put the controller in Test-Logic-Reset. The IDCODE instruction is then current.
- R2: While `rst_n` is low, and in every Test-Logic-Reset cycle, the current instruction becomes IDCODE. A data scan with no instruction load therefore returns the identification word.
- R3: The instruction register is 3 bits wide and shifts LSB first. It captures 001 in Capture-IR, and a new code takes effect only in Update-IR. The codes are: 000 external test, 001 IDCODE, 010 sample-with-outputs-floated, 100 sample/preload, 111 bypass. The reserved codes 011, 101 and 110 select bypass.
- R4: The identification word is 32'h0003_7069. Bit 0 is 1. Bits 11:1 hold the vendor code 00000110100. Bits 17:12 hold 110111 (width and density). Bits 23:18 hold 000000 (memory type). Bits 31:24 hold 0. All of these fields are parameters.
- R5: Under bypass, the data path is one stage that captures 0, so `tdo` repeats `tdi` one shift later.
- R6: The boundary chain has 138 cells and shifts LSB first. In Capture-DR, cells 0 to 136 load `pin_in[136:0]`, and cell 137 (the control cell) loads its own latched value.
- R7: `pin_out` and the latched control cell change only in Update-DR, and only under codes 000, 010 or 100.
- R8: Reset sets the latched control cell to 1 and `pin_out` to 0.
- R9: `bus_oe` equals the latched control cell under 000, is 0 under 010, and equals `core_oe` under every other code. `extest_en` is high exactly when 000 is current.
- R10: `tdo` and `tdo_oe` change only on falling `tck`. `tdo_oe` is high only during Shift-IR and Shift-DR, and `tdo` is 0 outside those states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | High while `tdo` carries shifted data |
| pin_in | input | 137 | Pin values sampled by the boundary chain |
| core_oe | input | 1 | Output enable from the functional core |
| pin_out | output | 137 | Latched boundary values for the pins |
| bus_oe | output | 1 | Enable for the data output drivers |
| extest_en | output | 1 | High while external test is current |

## Verification
The bound checker watches four things on every rising edge. It watches the reach-reset rule after five high `tms` samples and the IDCODE load in Test-Logic-Reset. It watches that instruction and pin outputs change only after their update states, that the sample-floated code disables the drivers, and that `tdo_oe` tracks the shift states. Shifted contents can only be judged by the bench's scenarios: the identification word, the bypass delay, the reserved codes, the boundary capture order, and the control cell's round trip through preload and external test. The bench also shows that `tdo` does not move at the rising edge.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [3:0] {
        TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
    } tap_state_e;

    localparam int IR_W = 3;
    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
    localparam logic [IR_W-1:0] OP_PRELOAD = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_BOUNDARY} dr_sel_e;

    function automatic logic [31:0] pack_id(input logic [7:0] rev, input logic [5:0] arch,
                                            input logic [5:0] dens, input logic [10:0] vendor);
        return {rev, arch, dens, vendor, 1'b1};
    endfunction
endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm import scan_pkg::*; (
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);
    typedef struct packed { tap_state_e st; } fsm_t;
    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            TLR:    fsm_d.st = tms ? TLR    : RTI;
            RTI:    fsm_d.st = tms ? SEL_DR : RTI;
            SEL_DR: fsm_d.st = tms ? SEL_IR : CAP_DR;
            CAP_DR: fsm_d.st = tms ? EX1_DR : SH_DR;
            SH_DR:  fsm_d.st = tms ? EX1_DR : SH_DR;
            EX1_DR: fsm_d.st = tms ? UPD_DR : PAU_DR;
            PAU_DR: fsm_d.st = tms ? EX2_DR : PAU_DR;
            EX2_DR: fsm_d.st = tms ? UPD_DR : SH_DR;
            UPD_DR: fsm_d.st = tms ? SEL_DR : RTI;
            SEL_IR: fsm_d.st = tms ? TLR    : CAP_IR;
            CAP_IR: fsm_d.st = tms ? EX1_IR : SH_IR;
            SH_IR:  fsm_d.st = tms ? EX1_IR : SH_IR;
            EX1_IR: fsm_d.st = tms ? UPD_IR : PAU_IR;
            PAU_IR: fsm_d.st = tms ? EX2_IR : PAU_IR;
            EX2_IR: fsm_d.st = tms ? UPD_IR : SH_IR;
            UPD_IR: fsm_d.st = tms ? SEL_DR : RTI;
            default: fsm_d.st = TLR;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: TLR};
        else        fsm_q <= fsm_d;
    end

    assign state = fsm_q.st;
endmodule

// File: rtl/scan_ir.sv
module scan_ir import scan_pkg::*; (
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic            ir_so,
    output logic [IR_W-1:0] instr,
    output dr_sel_e         dr_sel
);
    typedef struct packed {
        logic [IR_W-1:0] sr;
        logic [IR_W-1:0] op;
    } ir_t;
    ir_t ir_d, ir_q;

    always_comb begin
        ir_d = ir_q;
        case (state)
            TLR:     ir_d.op = OP_IDCODE;
            CAP_IR:  ir_d.sr = IR_CAPTURE;
            SH_IR:   ir_d.sr = {tdi, ir_q.sr[IR_W-1:1]};
            UPD_IR:  ir_d.op = ir_q.sr;
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) ir_q <= '{sr: '0, op: OP_IDCODE};
        else        ir_q <= ir_d;
    end

    always_comb begin
        case (ir_q.op)
            OP_EXTEST, OP_SAMPLEZ, OP_PRELOAD: dr_sel = DR_BOUNDARY;
            OP_IDCODE:                         dr_sel = DR_IDENT;
            default:                           dr_sel = DR_BYPASS;
        endcase
    end

    assign ir_so = ir_q.sr[0];
    assign instr = ir_q.op;
endmodule

// File: rtl/scan_bsc.sv
module scan_bsc #(
    parameter int LEN = 138
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            en,
    input  logic            capture,
    input  logic            shift,
    input  logic            update,
    input  logic            tdi,
    input  logic [LEN-2:0]  pin_in,
    output logic            so,
    output logic [LEN-2:0]  pin_out,
    output logic            ctl
);
    localparam int NPIN = LEN - 1;

    typedef struct packed {
        logic [LEN-1:0] sr;
        logic [LEN-1:0] upd;
    } bsc_t;
    bsc_t bsc_d, bsc_q;

    always_comb begin
        bsc_d = bsc_q;
        if (en) begin
            if (capture)     bsc_d.sr  = {bsc_q.upd[NPIN], pin_in};
            else if (shift)  bsc_d.sr  = {tdi, bsc_q.sr[LEN-1:1]};
            else if (update) bsc_d.upd = bsc_q.sr;
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) bsc_q <= '{sr: '0, upd: {1'b1, {NPIN{1'b0}}}};
        else        bsc_q <= bsc_d;
    end

    assign so      = bsc_q.sr[0];
    assign pin_out = bsc_q.upd[NPIN-1:0];
    assign ctl     = bsc_q.upd[NPIN];
endmodule

// File: rtl/scan_port.sv
module scan_port import scan_pkg::*; #(
    parameter int          BSC_LEN   = 138,
    parameter logic [7:0]  ID_REV    = 8'h00,
    parameter logic [5:0]  ID_ARCH   = 6'b000000,
    parameter logic [5:0]  ID_DENS   = 6'b110111,
    parameter logic [10:0] ID_VENDOR = 11'b00000110100
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_oe,
    input  logic [BSC_LEN-2:0] pin_in,
    input  logic               core_oe,
    output logic [BSC_LEN-2:0] pin_out,
    output logic               bus_oe,
    output logic               extest_en
);
    localparam int          ID_W     = 32;
    localparam logic [ID_W-1:0] ID_VALUE = pack_id(ID_REV, ID_ARCH, ID_DENS, ID_VENDOR);

    tap_state_e      state;
    logic            ir_so, bsc_so, ctl, dr_so;
    logic [IR_W-1:0] instr;
    dr_sel_e         dr_sel;
    logic            cap_dr, sh_dr, upd_dr, sh_ir;

    scan_tap_fsm i_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state(state));

    scan_ir i_ir (.tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
                  .ir_so(ir_so), .instr(instr), .dr_sel(dr_sel));

    assign cap_dr = (state == CAP_DR);
    assign sh_dr  = (state == SH_DR);
    assign upd_dr = (state == UPD_DR);
    assign sh_ir  = (state == SH_IR);

    scan_bsc #(.LEN(BSC_LEN)) i_bsc (
        .tck(tck), .rst_n(rst_n), .en(dr_sel == DR_BOUNDARY),
        .capture(cap_dr), .shift(sh_dr), .update(upd_dr), .tdi(tdi),
        .pin_in(pin_in), .so(bsc_so), .pin_out(pin_out), .ctl(ctl));

    typedef struct packed {
        logic [ID_W-1:0] id_sr;
        logic            byp;
    } core_t;
    core_t core_d, core_q;

    always_comb begin
        core_d = core_q;
        if (dr_sel == DR_IDENT) begin
            if (cap_dr)     core_d.id_sr = ID_VALUE;
            else if (sh_dr) core_d.id_sr = {tdi, core_q.id_sr[ID_W-1:1]};
        end else if (dr_sel == DR_BYPASS) begin
            if (cap_dr)     core_d.byp = 1'b0;
            else if (sh_dr) core_d.byp = tdi;
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    always_comb begin
        case (dr_sel)
            DR_IDENT:    dr_so = core_q.id_sr[0];
            DR_BOUNDARY: dr_so = bsc_so;
            default:     dr_so = core_q.byp;
        endcase
    end

    typedef struct packed {
        logic tdo;
        logic oe;
    } out_t;
    out_t out_d, out_q;

    always_comb begin
        out_d.oe  = sh_dr | sh_ir;
        out_d.tdo = sh_ir ? ir_so : (sh_dr ? dr_so : 1'b0);
    end

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign tdo    = out_q.tdo;
    assign tdo_oe = out_q.oe;

    always_comb begin
        case (instr)
            OP_EXTEST:  bus_oe = ctl;
            OP_SAMPLEZ: bus_oe = 1'b0;
            default:    bus_oe = core_oe;
        endcase
    end

    assign extest_en = (instr == OP_EXTEST);
endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk import scan_pkg::*; #(
    parameter int NPIN = 137
) (
    input logic            tck,
    input logic            rst_n,
    input logic            tms,
    input logic            tdo_oe,
    input logic            bus_oe,
    input logic [NPIN-1:0] pin_out,
    input logic [IR_W-1:0] instr,
    input tap_state_e      state
);
    logic [2:0] ones_q;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)             ones_q <= '0;
        else if (!tms)          ones_q <= '0;
        else if (ones_q != 3'd7) ones_q <= ones_q + 3'd1;
    end

    assert_five_tms_reset_R1: assert property (@(posedge tck) disable iff (!rst_n)
        ones_q >= 3'd5 |-> state == TLR);

    assert_reset_loads_idcode_R2: assert property (@(posedge tck) disable iff (!rst_n)
        state == TLR |=> instr == OP_IDCODE);

    assert_instr_update_only_R3: assert property (@(posedge tck) disable iff (!rst_n)
        !$stable(instr) |-> ($past(state) == UPD_IR || $past(state) == TLR));

    assert_pins_update_only_R7: assert property (@(posedge tck) disable iff (!rst_n)
        !$stable(pin_out) |-> $past(state) == UPD_DR);

    assert_samplez_floats_R9: assert property (@(posedge tck) disable iff (!rst_n)
        instr == OP_SAMPLEZ |-> !bus_oe);

    assert_tdo_oe_shift_R10: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe == (state == SH_DR || state == SH_IR));
endmodule

bind scan_port scan_port_chk #(.NPIN(BSC_LEN-1)) i_chk (
    .tck(tck), .rst_n(rst_n), .tms(tms), .tdo_oe(tdo_oe), .bus_oe(bus_oe),
    .pin_out(pin_out), .instr(instr), .state(state));

// File: tb/test_scan_port.sv
module test_scan_port;
    localparam int PERIOD = 20;
    localparam int NP = 137;
    localparam logic [31:0] ID_EXP = 32'h0003_7069;

    typedef struct packed {
        logic [2:0] code;
        logic [1:0] kind;   // 0 bypass, 1 ident, 2 boundary
        logic       core;
        logic       oe;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{3'b000, 2'd2, 1'b0, 1'b1},
        '{3'b001, 2'd1, 1'b1, 1'b1},
        '{3'b010, 2'd2, 1'b1, 1'b0},
        '{3'b011, 2'd0, 1'b0, 1'b0},
        '{3'b100, 2'd2, 1'b1, 1'b1},
        '{3'b101, 2'd0, 1'b1, 1'b1},
        '{3'b110, 2'd0, 1'b0, 1'b0},
        '{3'b111, 2'd0, 1'b1, 1'b1}
    };

    logic tck = 1'b0, rst_n = 1'b0, tms = 1'b1, tdi = 1'b1, core_oe = 1'b0;
    logic [NP-1:0] pin_in;
    logic tdo, tdo_oe, bus_oe, extest_en;
    logic [NP-1:0] pin_out;

    logic seen, seen_oe;
    logic [191:0] dr_in, dr_out, exp_v;
    logic [2:0] ir_cap;
    logic [NP-1:0] pause_pins;
    int checks = 0, fails = 0, glitches = 0;

    scan_port i_scan_port (.tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .tdo_oe(tdo_oe), .pin_in(pin_in), .core_oe(core_oe), .pin_out(pin_out),
        .bus_oe(bus_oe), .extest_en(extest_en));

    always #(PERIOD/2) tck = ~tck;

    task automatic check(input bit ok, input string req, input logic [191:0] act, input logic [191:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic tick(input logic m, input logic d);
        @(negedge tck); #2;
        tms = m; tdi = d;
        #5;
        seen = tdo; seen_oe = tdo_oe;
        @(posedge tck); #2;
        if (tdo !== seen) glitches++;
    endtask

    task automatic load_ir(input logic [2:0] code);
        tick(1, 1); tick(1, 1); tick(0, 1); tick(0, 1);
        for (int i = 0; i < 3; i++) begin
            tick(i == 2, code[i]);
            ir_cap[i] = seen;
        end
        tick(1, 1); tick(0, 1);
        #1;
    endtask

    task automatic shift_dr(input int n, input bit pause);
        tick(1, 1); tick(0, 1); tick(0, 1);
        dr_out = '0;
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, dr_in[i]);
            dr_out[i] = seen;
        end
        if (pause) begin
            tick(0, 1);
            #1 pause_pins = pin_out;
            tick(1, 1);
        end
        tick(1, 1); tick(0, 1);
        #1;
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) pin_in[i] = ((i * 7) % 5) < 2;
        for (int i = 0; i < 192; i++) dr_in[i] = ((i * 13) % 7) > 3;
        repeat (3) @(posedge tck);
        @(negedge tck); #3 rst_n = 1'b1;
        tick(0, 1);

        // Table walk: every instruction code
        for (int v = 0; v < 8; v++) begin
            core_oe = VEC[v].core;
            load_ir(VEC[v].code);
            check(ir_cap == 3'b001, "R3 IR capture", ir_cap, 3'b001);
            check(bus_oe == VEC[v].oe && extest_en == (VEC[v].code == 3'b000),
                  "R9 output enable mode", {bus_oe, extest_en}, {VEC[v].oe, VEC[v].code == 3'b000});
            shift_dr(40, 0);
            exp_v = '0;
            for (int i = 0; i < 40; i++) begin
                if (VEC[v].kind == 2'd0)      exp_v[i] = (i == 0) ? 1'b0 : dr_in[i-1];
                else if (VEC[v].kind == 2'd1) exp_v[i] = (i < 32) ? ID_EXP[i] : dr_in[i-32];
                else                          exp_v[i] = pin_in[i];
            end
            if (VEC[v].kind == 2'd0)      check(dr_out[39:0] == exp_v[39:0], "R5 bypass path", dr_out[39:0], exp_v[39:0]);
            else if (VEC[v].kind == 2'd1) check(dr_out[39:0] == exp_v[39:0], "R4 ident path", dr_out[39:0], exp_v[39:0]);
            else                          check(dr_out[39:0] == exp_v[39:0], "R6 boundary path", dr_out[39:0], exp_v[39:0]);
        end

        // Reset state and IDCODE default
        rst_n = 1'b0; core_oe = 1'b1;
        repeat (3) @(posedge tck);
        #3;
        check(tdo_oe == 1'b0 && tdo == 1'b0, "R10 reset tdo", {tdo_oe, tdo}, 2'b00);
        check(pin_out == '0 && bus_oe == 1'b1 && !extest_en, "R8 reset outputs", {pin_out, bus_oe, extest_en}, {{NP{1'b0}}, 2'b10});
        @(negedge tck); #3 rst_n = 1'b1;
        tick(0, 1);
        shift_dr(32, 0);
        check(dr_out[31:0] == ID_EXP, "R2 default IDCODE after reset", dr_out[31:0], ID_EXP);

        // Five TMS highs from inside Shift-DR
        load_ir(3'b111);
        tick(1, 1); tick(0, 1); tick(0, 1); tick(0, 0); tick(0, 1);
        for (int i = 0; i < 5; i++) tick(1, 1);
        tick(0, 1);
        shift_dr(32, 0);
        check(dr_out[31:0] == ID_EXP, "R1 tms reset restores IDCODE", dr_out[31:0], ID_EXP);

        // Control cell preset high
        core_oe = 1'b0;
        load_ir(3'b000);
        check(bus_oe == 1'b1 && extest_en, "R8 control cell preset", {bus_oe, extest_en}, 2'b11);

        // Preload: outputs move only at Update-DR
        core_oe = 1'b1;
        load_ir(3'b100);
        dr_in[NP-1:0] = ~pin_in; dr_in[NP] = 1'b0;
        shift_dr(NP + 1, 1);
        check(pause_pins == '0, "R7 no change before update", pause_pins, '0);
        check(pin_out == ~pin_in, "R7 preload update", pin_out, ~pin_in);
        check(dr_out[NP-1:0] == pin_in && dr_out[NP] == 1'b1, "R6 capture incl control", dr_out[NP:0], {1'b1, pin_in});
        check(bus_oe == 1'b1, "R9 preload keeps core enable", bus_oe, 1'b1);

        // EXTEST applies the preloaded control cell
        core_oe = 1'b1;
        load_ir(3'b000);
        check(bus_oe == 1'b0 && pin_out == ~pin_in, "R9 extest control low", {bus_oe, pin_out}, {1'b0, ~pin_in});
        dr_in[NP-1:0] = pin_in; dr_in[NP] = 1'b1;
        shift_dr(NP + 1, 0);
        check(dr_out[NP] == 1'b0, "R6 control cell captures latched value", dr_out[NP], 1'b0);
        check(bus_oe == 1'b1 && pin_out == pin_in, "R9 extest control high", {bus_oe, pin_out}, {1'b1, pin_in});

        check(glitches == 0, "R10 tdo stable at rising edge", glitches, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule